// File: doc/BRIEF.md
# Grouped Interrupt Aggregator Controller

This block gathers sixteen active-low request lines from the board into one pending-flag register. Software gates each source through a mask register. Every source that is both pending and enabled is steered onto one of four request outputs, and each output has a fixed set of sources that are not contiguous. Fifteen of the sources are sampled as low levels. The top source is a push button. It passes through a two-flop synchroniser and only its falling edge records an event.

Software reaches the block over a small 16-bit register bus with a byte address, write enable, write data, read enable and read data. The mask and the flags can both be read back. A handler acknowledges a source by writing the flag register with a zero in that source's bit and ones in all the others. The usual setup masks every level source and leaves bits 0 and 15 enabled. Neither of those two bits belongs to an output group.

Top module: `irqagg_top`

## Requirements
- R1: After synchronous reset the mask register reads 0xFFFF, the flag register reads 0x0000 and all four `irq_out` bits are 0.
- R2: The mask register is at byte address 0x4 and the flag register at 0xC. A read captures the addressed register on the clock edge where `rd_en` is high, and `rd_data` then holds that value until the next read. Any other address reads 0x0000.
- R3: A write to address 0x4 loads `wr_data` into the mask. A mask bit of 1 disables its source and a 0 enables it.
- R4: A write to address 0xC clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. Writing 0xFFFF therefore leaves the flags unchanged.
- R5: Sources 0 to 14 are active low and level sensitive. Flag k is set on every clock edge at which `src_n[k]` is sampled low.
- R6: A clear written while a level source is still low leaves its flag at 1, because the set wins over the clear in the same cycle.
- R7: Source 15 passes through two flops, and its flag is set on the third clock edge after `src_n[15]` falls. Holding it low afterwards does not set the flag again once it has been cleared.
- R8: If a source-15 edge and a clear of bit 15 land on the same clock edge, flag 15 ends up at 1.
- R9: `irq_out[g]` is the OR, over the sources of group g, of flag AND NOT mask. The groups are g0 = 0x0028, g1 = 0x0050, g2 = 0x1C00 and g3 = 0x6386. The outputs are combinational from the registers.
- R10: Flags 0 and 15 belong to no group. They can be read back but never assert any output.
- R11: The mask does not stop a flag from being recorded. It only gates that flag's effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_n | input | 16 | Active-low request lines, one per source |
| addr | input | 4 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| irq_out | output | 4 | Grouped request outputs |

## Verification
The hardest cases to reach from the ports are collisions between a source setting its flag and a software clear on the same edge. For a level source this happens while the line is still held low. For the button it happens when the clear lands exactly on the edge where the synchroniser's detected fall registers, which is three edges after the pin drops. Directed sequences place the clear write on that exact edge and also issue a clear while a level line is still held. Long seeded random runs then mix line activity with mask and flag writes, and a cycle-level model in the bench follows every combination.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int SRC_W  = 16;
    localparam int OUT_N  = 4;
    localparam int ADDR_W = 4;

    typedef logic [SRC_W-1:0]  src_vec_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t MASK_OFS = 4'h4;
    localparam addr_t FLAG_OFS = 4'hC;

    localparam src_vec_t MASK_RST = '1;
    localparam src_vec_t FLAG_RST = '0;

    // sources sampled through the falling-edge path
    localparam src_vec_t EDGE_SEL = 16'h8000;

    localparam src_vec_t GROUP_SEL [OUT_N] = '{16'h0028, 16'h0050, 16'h1C00, 16'h6386};

    typedef enum logic {
        SENSE_LEVEL_LOW,
        SENSE_FALL_EDGE
    } sense_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        addr_t    addr;
        src_vec_t data;
    } bus_req_t;

    function automatic sense_e sense_of(input int idx);
        return EDGE_SEL[idx] ? SENSE_FALL_EDGE : SENSE_LEVEL_LOW;
    endfunction

    function automatic src_vec_t any_group();
        src_vec_t acc;
        acc = '0;
        for (int g = 0; g < OUT_N; g++) acc |= GROUP_SEL[g];
        return acc;
    endfunction

endpackage

// File: rtl/irqagg_detect.sv
module irqagg_detect
    import irqagg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t src_n,
    output src_vec_t set_vec
);

    for (genvar i = 0; i < SRC_W; i++) begin : g_src
        if (sense_of(i) == SENSE_FALL_EDGE) begin : g_edge
            logic s1_q, s2_q, prev_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1_q   <= 1'b1;
                    s2_q   <= 1'b1;
                    prev_q <= 1'b1;
                end else begin
                    s1_q   <= src_n[i];
                    s2_q   <= s1_q;
                    prev_q <= s2_q;
                end
            end
            assign set_vec[i] = prev_q & ~s2_q;
        end else begin : g_level
            assign set_vec[i] = ~src_n[i];
        end
    end

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  src_vec_t set_vec,
    output src_vec_t mask_q,
    output src_vec_t flag_q,
    output src_vec_t rd_q
);

    logic     hit_mask, hit_flag;
    src_vec_t keep_vec, flag_d, rd_sel;

    always_comb begin
        hit_mask = req.wr && (req.addr == MASK_OFS);
        hit_flag = req.wr && (req.addr == FLAG_OFS);
        keep_vec = hit_flag ? req.data : '1;
        flag_d   = (flag_q & keep_vec) | set_vec;
        unique case (req.addr)
            MASK_OFS: rd_sel = mask_q;
            FLAG_OFS: rd_sel = flag_q;
            default:  rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= MASK_RST;
            flag_q <= FLAG_RST;
            rd_q   <= '0;
        end else begin
            flag_q <= flag_d;
            if (hit_mask) mask_q <= req.data;
            if (req.rd)   rd_q   <= rd_sel;
        end
    end

endmodule

// File: rtl/irqagg_route.sv
module irqagg_route
    import irqagg_pkg::*;
(
    input  src_vec_t         flag_q,
    input  src_vec_t         mask_q,
    output logic [OUT_N-1:0] irq_out
);

    src_vec_t live;
    assign live = flag_q & ~mask_q;

    for (genvar g = 0; g < OUT_N; g++) begin : g_out
        assign irq_out[g] = |(live & GROUP_SEL[g]);
    end

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  src_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [SRC_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [SRC_W-1:0]  rd_data,
    output logic [OUT_N-1:0]  irq_out
);

    bus_req_t req;
    src_vec_t set_vec, mask_q, flag_q;

    assign req = '{wr: wr_en, rd: rd_en, addr: addr, data: wr_data};

    irqagg_detect i_detect (
        .clk     (clk),
        .rst     (rst),
        .src_n   (src_n),
        .set_vec (set_vec)
    );

    irqagg_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .set_vec (set_vec),
        .mask_q  (mask_q),
        .flag_q  (flag_q),
        .rd_q    (rd_data)
    );

    irqagg_route i_route (
        .flag_q  (flag_q),
        .mask_q  (mask_q),
        .irq_out (irq_out)
    );

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
    import irqagg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SRC_W-1:0]  src_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [SRC_W-1:0]  wr_data,
    input logic [OUT_N-1:0]  irq_out,
    input logic [SRC_W-1:0]  mask_q,
    input logic [SRC_W-1:0]  flag_q,
    input logic [SRC_W-1:0]  set_vec
);

    localparam int       TOP = SRC_W - 1;
    localparam src_vec_t GRP_ALL = any_group();

    logic     wr_mask, wr_flag;
    src_vec_t lvl_low;
    assign wr_mask = wr_en && (addr == MASK_OFS);
    assign wr_flag = wr_en && (addr == FLAG_OFS);
    assign lvl_low = ~src_n & ~EDGE_SEL;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == MASK_RST && flag_q == FLAG_RST && irq_out == '0));

    assert_mask_load_R3: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> mask_q == $past(wr_data));

    assert_keep_ones_R4: assert property (@(posedge clk) disable iff (rst)
        wr_flag |=> ((($past(flag_q) & $past(wr_data)) & ~flag_q) == '0));

    assert_level_set_R5: assert property (@(posedge clk) disable iff (rst)
        (|lvl_low) |=> ((flag_q & $past(lvl_low)) == $past(lvl_low)));

    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (set_vec[TOP] && wr_flag) |=> flag_q[TOP]);

    assert_orphan_bits_R10: assert property (@(posedge clk) disable iff (rst)
        ((flag_q & ~mask_q & GRP_ALL) == '0) |-> irq_out == '0);

    for (genvar g = 0; g < OUT_N; g++) begin : g_grp
        assert_group_drive_R9: assert property (@(posedge clk) disable iff (rst)
            (|(flag_q & ~mask_q & GROUP_SEL[g])) |-> irq_out[g]);
    end

endmodule

bind irqagg_top irqagg_checker i_chk (
    .clk     (clk),
    .rst     (rst),
    .src_n   (src_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .irq_out (irq_out),
    .mask_q  (mask_q),
    .flag_q  (flag_q),
    .set_vec (set_vec)
);

// File: tb/test_irqagg_top.sv
module test_irqagg_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_n = 16'hFFFF;
    logic [3:0]  addr = 4'h0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic [3:0]  irq_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqagg_top i_irqagg_top (
        .clk(clk), .rst(rst), .src_n(src_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_out(irq_out)
    );

    // cycle model built from the requirements
    logic [15:0] m_mask, m_flag, m_rd, m_set;
    logic        m_s1, m_s2, m_prev;

    assign m_set = {m_prev & ~m_s2, ~src_n[14:0]};

    always @(posedge clk) begin
        if (rst) begin
            m_mask <= 16'hFFFF; m_flag <= 16'h0; m_rd <= 16'h0;
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_prev <= 1'b1;
        end else begin
            m_s1 <= src_n[15]; m_s2 <= m_s1; m_prev <= m_s2;
            m_flag <= (m_flag & ((wr_en && addr == 4'hC) ? wr_data : 16'hFFFF)) | m_set;
            if (wr_en && addr == 4'h4) m_mask <= wr_data;
            if (rd_en) m_rd <= (addr == 4'h4) ? m_mask : (addr == 4'hC) ? m_flag : 16'h0;
        end
    end

    function automatic logic [3:0] exp_out(input logic [15:0] f, input logic [15:0] m);
        logic [15:0] grp [4];
        logic [3:0]  o;
        grp[0] = 16'h0028; grp[1] = 16'h0050; grp[2] = 16'h1C00; grp[3] = 16'h6386;
        for (int g = 0; g < 4; g++) o[g] = |(f & ~m & grp[g]);
        return o;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // continuous comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R9 outputs", {12'h0, irq_out}, {12'h0, exp_out(m_flag, m_mask)});
            check("R2 read data", rd_data, m_rd);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    logic [15:0] v;

    initial begin
        void'($urandom(32'h1D5E));
        cyc(3);
        rst = 1'b0;
        // R1 reset state
        check("R1 irq_out", {12'h0, irq_out}, 16'h0);
        rd(4'h4, v); check("R1 mask", v, 16'hFFFF);
        rd(4'hC, v); check("R1 flag", v, 16'h0000);
        rd(4'h8, v); check("R2 unmapped", v, 16'h0000);
        // R3 mask load
        wr(4'h4, 16'h7FFE);
        rd(4'h4, v); check("R3 mask", v, 16'h7FFE);
        // R5 / R11: masked level source still records
        src_n[3] = 1'b0;
        cyc(1);
        rd(4'hC, v); check("R5 R11 flag", v, 16'h0008);
        check("R11 masked out", {12'h0, irq_out}, 16'h0);
        wr(4'h4, 16'h7FF6);
        check("R9 group0", {12'h0, irq_out}, 16'h0001);
        // R6 clear while still low
        wr(4'hC, 16'h0000);
        rd(4'hC, v); check("R6 reset by level", v, 16'h0008);
        src_n[3] = 1'b1;
        cyc(1);
        wr(4'hC, 16'hFFFF);
        rd(4'hC, v); check("R4 all ones", v, 16'h0008);
        wr(4'hC, 16'hFFF7);
        rd(4'hC, v); check("R4 clear", v, 16'h0000);
        check("R4 out idle", {12'h0, irq_out}, 16'h0);
        // R10 bit 0
        wr(4'h4, 16'h0000);
        src_n[0] = 1'b0; cyc(1); src_n[0] = 1'b1; cyc(1);
        rd(4'hC, v); check("R10 bit0 flag", v, 16'h0001);
        check("R10 bit0 out", {12'h0, irq_out}, 16'h0);
        wr(4'hC, 16'h0000);
        // R7 button edge, third edge
        src_n[15] = 1'b0;
        cyc(2);
        rd(4'hC, v); check("R7 not yet", v, 16'h0000);
        rd(4'hC, v); check("R7 edge flag", v, 16'h8000);
        check("R10 bit15 out", {12'h0, irq_out}, 16'h0);
        wr(4'hC, 16'h0000);
        cyc(3);
        rd(4'hC, v); check("R7 held low", v, 16'h0000);
        src_n[15] = 1'b1;
        cyc(4);
        // R8 edge collides with clear on the third edge
        src_n[15] = 1'b0;
        cyc(2);
        wr(4'hC, 16'h0000);
        rd(4'hC, v); check("R8 set wins", v, 16'h8000);
        src_n[15] = 1'b1;
        wr(4'hC, 16'h0000);
        cyc(3);
        // random phase, compared by the model above
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] lo;
            lo = 16'($urandom) & 16'($urandom) & 16'($urandom);
            src_n[14:0] = ~lo[14:0];
            if (($urandom % 6) == 0) src_n[15] = ~src_n[15];
            case ($urandom % 4)
                0: addr = 4'h0; 1: addr = 4'h4; 2: addr = 4'h8; default: addr = 4'hC;
            endcase
            wr_en   = (($urandom % 4) == 0);
            wr_data = (addr == 4'h4) ? (16'($urandom) | 16'($urandom)) : 16'($urandom);
            rd_en   = (($urandom % 2) == 0);
            @(negedge clk);
        end
        wr_en = 1'b0; rd_en = 1'b0;
        cyc(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule